// File: doc/BRIEF.md
# DMA Descriptor Ownership Counter

This block keeps, for each of four DMA channels, the number of ring descriptors that software has handed to the engine and that the engine has not yet used. Software grants descriptors by writing a value to a channel's count register. The write adds that value to the count instead of replacing it. Software can therefore top up a channel while the engine is draining it, with no read-modify-write race.

The engine pulses a per-channel consume strobe each time it finishes a descriptor. A consume lowers the count by one. It also steps the channel's current descriptor address through a ring, using a programmable base and a programmable size given in descriptors. Each descriptor is 16 bytes.

Software reads either of two words on a combinational read port:
- the count register;
- a status word that packs the current address together with the live count.

Each channel also drives a busy line to the engine and a sticky overflow flag.

Top module: `dscr_own_ctr`

## Requirements
- R1: After reset, every channel has count 0, overflow flag 0, busy 0, ring base 0, ring size 0 and current address 0.
- R2: A write with wr_sel_i = 0 adds wr_data_i[15:0] to the selected channel's count. The upper data bits are ignored.
- R3: A read with rd_sel_i = 0 returns the channel's count in bits 15:0, with bits 63:16 zero.
- R4: A read with rd_sel_i = 1 returns the current address in bits 39:0, zero in bits 47:40 and the count in bits 63:48.
- R5: Channels are independent. A write or consume on one channel leaves every other channel's count, address and flags unchanged.
- R6: An add and a consume on the same channel in the same cycle give count + value − 1.
- R7: A consume while the count is zero is ignored. The count stays 0 and the address does not move.
- R8: An add whose result would exceed 0xFFFF leaves the count at 0xFFFF and sets that channel's overflow flag. The flag stays set until reset.
- R9: Each accepted consume advances the current address by 16 bytes. After ring-size descriptors it returns to the base; a size of 0 or 1 keeps it at the base. A write with wr_sel_i = 1 loads the base from wr_data_i[39:0]. A write with wr_sel_i = 2 loads the size from wr_data_i[15:0]. Either write resets the address to the base, and takes priority over a consume in the same cycle. wr_sel_i = 3 has no effect.
- R10: busy_o for a channel is high exactly when that channel's count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 2 | Channel addressed by the write |
| wr_sel_i | input | 2 | Write target: 0 add count, 1 ring base, 2 ring size, 3 none |
| wr_data_i | input | 64 | Write data |
| rd_ch_i | input | 2 | Channel addressed by the read |
| rd_sel_i | input | 1 | Read target: 0 count register, 1 status word |
| rd_data_o | output | 64 | Read data (combinational) |
| consume_i | input | 4 | Per-channel descriptor-done strobe from the engine |
| busy_o | output | 4 | Per-channel count-nonzero indication |
| ovf_o | output | 4 | Per-channel sticky overflow flag |

## Verification
The assertions assume only that consume strobes and writes are sampled once per clock. Holding a strobe high for several cycles therefore counts as several events.

Under that assumption, the saturation and ring-stride properties are guarded so that they fire only when the add value, the count and the ring index make the outcome unambiguous. The stimulus mostly uses small add values and ring sizes of 0 to 5, so consumes, wraps and drains to zero all occur often. Separate directed steps push one channel to saturation and also issue a consume at count zero.

// File: rtl/dscr_own_pkg.sv
package dscr_own_pkg;
  typedef enum logic [1:0] {
    WSEL_ADD  = 2'd0,
    WSEL_BASE = 2'd1,
    WSEL_SIZE = 2'd2,
    WSEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic {
    RSEL_COUNT  = 1'b0,
    RSEL_STATUS = 1'b1
  } rsel_e;
endpackage

// File: rtl/dscr_cnt.sv
module dscr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [CNT_W-1:0] add_val_i,
  input  logic             consume_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             take_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   add_ext;
  logic [CNT_W:0]   sum;

  // a consume is accepted only while descriptors remain
  assign take_o  = consume_i && (cnt_q != '0);
  assign add_ext = add_i ? {1'b0, add_val_i} : '0;
  assign sum     = {1'b0, cnt_q} + add_ext - (CNT_W+1)'(take_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (sum[CNT_W]) begin
      cnt_q <= '1;
      ovf_q <= 1'b1;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R2: plain add with no saturation risk
  a_r2_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !consume_i && !cnt_o[CNT_W-1] && !add_val_i[CNT_W-1])
      |=> cnt_o == $past(cnt_o) + $past(add_val_i));

  a_r6_add_and_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && consume_i && cnt_o != '0 && !cnt_o[CNT_W-1] && !add_val_i[CNT_W-1])
      |=> cnt_o == $past(cnt_o) + $past(add_val_i) - 1'b1);

  a_r7_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && cnt_o == '0 && !add_i) |=> cnt_o == '0);

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && add_val_i > 1 && (&cnt_o)) |=> ((&cnt_o) && ovf_o));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/dscr_ring.sv
module dscr_ring #(
  parameter int ADDR_W  = 40,
  parameter int IDX_W   = 16,
  parameter int DSCR_LG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic              size_we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  size_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << DSCR_LG;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  size_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W:0]    idx_nx;
  logic              wrap;

  assign idx_nx = {1'b0, idx_q} + 1'b1;
  assign wrap   = idx_nx >= {1'b0, size_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      size_q <= '0;
      idx_q  <= '0;
    end else if (base_we_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (size_we_i) begin
      size_q <= size_i;
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q <= wrap ? '0 : idx_nx[IDX_W-1:0];
    end
  end

  assign addr_o = base_q + (ADDR_W'(idx_q) << DSCR_LG);

  a_r9_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !base_we_i && !size_we_i && !wrap)
      |=> addr_o == $past(addr_o) + STRIDE);

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !base_we_i && !size_we_i && wrap) |=> addr_o == $past(base_q));

  a_r9_base_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> addr_o == $past(base_i));
endmodule

// File: rtl/dscr_rd_mux.sv
module dscr_rd_mux
  import dscr_own_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] addr_i,
  input  logic [CH_W-1:0]               rd_ch_i,
  input  logic                          rd_sel_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  logic [CNT_W-1:0]  cnt_s;
  logic [ADDR_W-1:0] addr_s;

  assign cnt_s  = cnt_i[rd_ch_i];
  assign addr_s = addr_i[rd_ch_i];

  always_comb begin
    rd_data_o = '0;
    if (rsel_e'(rd_sel_i) == RSEL_STATUS) begin
      rd_data_o[ADDR_W-1:0]       = addr_s;
      rd_data_o[DATA_W-1 -: CNT_W] = cnt_s;
    end else begin
      rd_data_o[CNT_W-1:0] = cnt_s;
    end
  end

  initial begin
    a_r4_layout_fits: assert (ADDR_W + CNT_W <= DATA_W);
  end
endmodule

// File: rtl/dscr_own_ctr.sv
module dscr_own_ctr
  import dscr_own_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 40,
  parameter int DSCR_LG = 4,
  parameter int DATA_W  = 64,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NUM_CH-1:0] consume_i,
  output logic [NUM_CH-1:0] busy_o,
  output logic [NUM_CH-1:0] ovf_o
);
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt;
  logic [NUM_CH-1:0][ADDR_W-1:0] addr;
  logic [NUM_CH-1:0]             take;
  logic [NUM_CH-1:0]             hit;
  wsel_e                         wsel;

  assign wsel = wsel_e'(wr_sel_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = wr_en_i && (wr_ch_i == CH_W'(g));

    dscr_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .add_i     (hit[g] && wsel == WSEL_ADD),
      .add_val_i (wr_data_i[CNT_W-1:0]),
      .consume_i (consume_i[g]),
      .cnt_o     (cnt[g]),
      .ovf_o     (ovf_o[g]),
      .take_o    (take[g])
    );

    dscr_ring #(.ADDR_W(ADDR_W), .IDX_W(CNT_W), .DSCR_LG(DSCR_LG)) u_ring (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .base_we_i (hit[g] && wsel == WSEL_BASE),
      .size_we_i (hit[g] && wsel == WSEL_SIZE),
      .base_i    (wr_data_i[ADDR_W-1:0]),
      .size_i    (wr_data_i[CNT_W-1:0]),
      .adv_i     (take[g]),
      .addr_o    (addr[g])
    );

    assign busy_o[g] = |cnt[g];

    // R10: busy can only rise after an add to this channel
    a_r10_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o[g] |=> (!busy_o[g] || $past(hit[g] && wsel == WSEL_ADD)));

    // R5: an idle channel holds its count and address
    a_r5_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit[g] && !consume_i[g]) |=> ($stable(cnt[g]) && $stable(addr[g])));

    a_r7_no_move_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o[g] && !hit[g]) |=> $stable(addr[g]));
  end

  dscr_rd_mux #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .cnt_i     (cnt),
    .addr_i    (addr),
    .rd_ch_i   (rd_ch_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/dscr_own_ctr_test.sv
`timescale 1ns/100ps
module dscr_own_ctr_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_ch_i = '0;
  logic [1:0]  wr_sel_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  rd_ch_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [63:0] rd_data_o;
  logic [3:0]  consume_i = '0;
  logic [3:0]  busy_o;
  logic [3:0]  ovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int unsigned m_cnt [4];
  bit          m_ovf [4];
  logic [39:0] m_base [4];
  int unsigned m_size [4];
  int unsigned m_idx [4];

  always #10 clk = ~clk;

  dscr_own_ctr uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_ch_i(rd_ch_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .consume_i(consume_i),
    .busy_o(busy_o), .ovf_o(ovf_o)
  );

  function automatic logic [39:0] m_addr(int c);
    return m_base[c] + (40'(m_idx[c]) << 4);
  endfunction

  function automatic void m_step(bit we, int ch, int sel, logic [63:0] d, logic [3:0] cons);
    for (int c = 0; c < 4; c++) begin
      bit hit = we && ch == c;
      bit tk  = cons[c] && m_cnt[c] != 0;
      int unsigned full = m_cnt[c] + ((hit && sel == 0) ? int'(d[15:0]) : 0) - (tk ? 1 : 0);
      if (full > 65535) begin m_cnt[c] = 65535; m_ovf[c] = 1'b1; end
      else m_cnt[c] = full;
      if (hit && sel == 1) begin m_base[c] = d[39:0]; m_idx[c] = 0; end
      else if (hit && sel == 2) begin m_size[c] = d[15:0]; m_idx[c] = 0; end
      else if (tk) m_idx[c] = (m_idx[c] + 1 >= m_size[c]) ? 0 : m_idx[c] + 1;
    end
  endfunction

  task automatic cyc(bit we, int ch, int sel, logic [63:0] d, logic [3:0] cons);
    wr_en_i = we; wr_ch_i = 2'(ch); wr_sel_i = 2'(sel); wr_data_i = d; consume_i = cons;
    @(posedge clk);
    m_step(we, ch, sel, d, cons);
    @(negedge clk);
    wr_en_i = 1'b0; consume_i = '0;
  endtask

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk(int c, string tag);
    rd_ch_i = 2'(c);
    rd_sel_i = 1'b0; #0.2;
    cmp({tag, " R3 count"}, rd_data_o, {48'b0, 16'(m_cnt[c])});
    rd_sel_i = 1'b1; #0.2;
    cmp({tag, " R4 status"}, rd_data_o, {16'(m_cnt[c]), 8'b0, m_addr(c)});
    cmp({tag, " R10 busy"}, 64'(busy_o[c]), 64'(m_cnt[c] != 0));
    cmp({tag, " R8 ovf"}, 64'(ovf_o[c]), 64'(m_ovf[c]));
  endtask

  task automatic chk_all(string tag);
    for (int c = 0; c < 4; c++) chk(c, tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7919));
    for (int c = 0; c < 4; c++) begin
      m_cnt[c] = 0; m_ovf[c] = 0; m_base[c] = '0; m_size[c] = 0; m_idx[c] = 0;
    end
    #45 rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    cyc(1, 0, 0, 64'd5, 4'b0);                    chk(0, "R2 add5");
    cyc(1, 0, 0, 64'hFFFF_0000_0000_0003, 4'b0);  chk(0, "R2 upper ignored");
    chk(1, "R5 ch1 untouched");
    cyc(1, 0, 1, 64'h00AA_0012_3456_7800, 4'b0);  chk(0, "R9 base");
    cyc(1, 0, 2, 64'd3, 4'b0);                    chk(0, "R9 size");
    cyc(0, 0, 0, '0, 4'b0001);                    chk(0, "R9 step1");
    cyc(0, 0, 0, '0, 4'b0001);                    chk(0, "R9 step2");
    cyc(0, 0, 0, '0, 4'b0001);                    chk(0, "R9 wrap");
    cyc(1, 0, 0, 64'd4, 4'b0001);                 chk(0, "R6 add+consume");
    cyc(1, 0, 3, 64'd99, 4'b0);                   chk(0, "R9 sel3 no effect");
    cyc(0, 0, 0, '0, 4'b0100);                    chk(2, "R7 consume at zero");
    cyc(1, 2, 0, 64'd0, 4'b0100);                 chk(2, "R7 zero add consume");
    cyc(1, 3, 0, 64'hFFF0, 4'b0);                 chk(3, "R8 near max");
    cyc(1, 3, 0, 64'h20, 4'b0);                   chk(3, "R8 saturate");
    cyc(0, 0, 0, '0, 4'b1000);                    chk(3, "R8 sticky");
    chk(1, "R5 ch1 after others");
    while (m_cnt[0] != 0) cyc(0, 0, 0, '0, 4'b0001);
    chk(0, "R10 drained");

    for (int i = 0; i < 1500; i++) begin
      int sel = ($urandom % 8 < 5) ? 0 : int'($urandom % 4);
      logic [63:0] d;
      case (sel)
        0: d = {$urandom, 32'($urandom % 8)};
        1: d = {$urandom, $urandom};
        default: d = 64'($urandom % 6);
      endcase
      cyc($urandom % 2 == 0, int'($urandom % 4), sel, d, 4'($urandom));
      chk_all("R5 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule